// File: doc/BRIEF.md
# Serial Flash Clock and Chip-Select Timer

This block derives the serial clock and the active-low device selects of a serial flash port from a faster reference clock. It runs the framing of one transaction: an optional gap when the target device changes, then select assertion, a setup wait, a programmable number of serial clock periods, a hold wait and a minimum deselect time. A transfer engine asks for a transaction with a one-cycle start request and a length. It gets back a strobe that marks every capture edge of the serial clock, and an idle flag that shows when a new request will be accepted.

Configuration comes in as static levels: divider, polarity, phase, select field, decoder mode and four delays. The block copies them into shadow registers on every clock while the enable input is low and holds them while enable is high. Software therefore clears enable, changes settings and sets enable again. Every delay is counted in reference cycles. The block adds a fixed overhead to the hold and deselect delays.

Top module: `sclk_cs_timer`

## Requirements
- R1: With divider field D (0..15), each serial clock level lasts D+1 reference cycles, so one serial clock period is 2*(D+1) reference cycles.
- R2: Outside a transaction the serial clock rests at the polarity bit. A transaction with length field N produces exactly N+1 periods, which is 2*(N+1) edges, and the clock ends at the rest level.
- R3: The capture strobe pulses once per serial period, in the same cycle the clock changes. The pulse marks the first edge of each period when the phase bit is 0 and the second edge when the phase bit is 1.
- R4: With the decoder mode bit at 0, a select field value n below 4 drives all select lines high except line n, which is driven low. Values of 4 or more keep all lines high. The select pattern does not change during a transaction.
- R5: With the decoder mode bit at 1, the select field value is driven onto the select lines unchanged while a transaction is active.
- R6: The first serial clock edge comes setup+1+(D+1) reference cycles after the selects assert, where setup is the programmed setup delay.
- R7: The selects deassert hold+2*(D+1)+3 reference cycles after the last serial clock edge, where hold is the programmed hold delay.
- R8: The idle flag rises deselect+2*(D+1)+1 reference cycles after the selects deassert, where deselect is the programmed deselect delay. The selects are all high whenever idle is high.
- R9: When a transaction's select pattern differs from the previous transaction's pattern, the selects assert gap cycles after the clock edge that accepts the start, where gap is the programmed gap delay. Otherwise they assert at that same edge.
- R10: Changes to configuration inputs while enable is high have no effect on timing, polarity or selects.
- R11: A start request is accepted only when enable is high and idle is high. When it is accepted, idle falls at that edge. A start request seen while disabled or busy is ignored.
- R12: Clearing enable aborts any transaction. After the next edge idle is high, all selects are high, the serial clock is at rest and no strobe is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Block enable; configuration is copied while low |
| cfg_div | input | 4 | Serial clock divider field |
| cfg_cpol | input | 1 | Serial clock rest level |
| cfg_cpha | input | 1 | Capture edge select |
| cfg_sel | input | 4 | Device index, or raw select pattern in decoder mode |
| cfg_decode | input | 1 | 1: drive the select field as-is; 0: one-hot from index |
| cfg_setup_dly | input | 8 | Select-to-first-edge delay |
| cfg_hold_dly | input | 8 | Last-edge-to-deselect delay |
| cfg_desel_dly | input | 8 | Minimum deselect time |
| cfg_gap_dly | input | 8 | Delay before selecting a different device |
| xfer_start | input | 1 | Transaction request, one cycle |
| xfer_len | input | 8 | Serial clock periods minus one |
| sclk | output | 1 | Serial clock |
| cs_n | output | 4 | Active-low device selects |
| cap_stb | output | 1 | Capture edge strobe |
| idle | output | 1 | No transaction and all delays expired |

## Verification
A timer loaded off by one moves a single port event, such as the first clock edge, the deselect edge or the idle rise, by one reference cycle within one transaction. The bench measures each of these events as an exact cycle count from the accepting edge. A wrong half-period count or edge counter shows as uneven clock spacing, or as the wrong number of edges and strobes, before the select is released. A stale shadow register or a missing abort path shows in the first transaction that follows the illegal change.

// File: rtl/sct_pkg.sv
// Shared sequencing state of the serial clock and select timer.
// Assumes nothing beyond a single clock domain.
package sct_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_GAP   = 3'd1,
        ST_SETUP = 3'd2,
        ST_RUN   = 3'd3,
        ST_HOLD  = 3'd4,
        ST_DESEL = 3'd5
    } sct_state_e;
endpackage

// File: rtl/sct_cfg.sv
// Configuration shadow: copies the configuration inputs every clock while
// the block is disabled and freezes them while it is enabled. Also forms
// the active-low select pattern from the select field and the decoder mode.
// Assumes the select field is CS_W bits wide and doubles as a device index.
module sct_cfg #(
    parameter int DIV_W = 4,
    parameter int CS_W  = 4,
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [DIV_W-1:0] in_div,
    input  logic             in_cpol,
    input  logic             in_cpha,
    input  logic [CS_W-1:0]  in_sel,
    input  logic             in_decode,
    input  logic [DLY_W-1:0] in_setup,
    input  logic [DLY_W-1:0] in_hold,
    input  logic [DLY_W-1:0] in_desel,
    input  logic [DLY_W-1:0] in_gap,
    output logic [DIV_W-1:0] div,
    output logic             cpol,
    output logic             cpha,
    output logic [DLY_W-1:0] d_setup,
    output logic [DLY_W-1:0] d_hold,
    output logic [DLY_W-1:0] d_desel,
    output logic [DLY_W-1:0] d_gap,
    output logic [CS_W-1:0]  pat
);
    logic [CS_W-1:0] sel_q;
    logic            decode_q;
    logic [CS_W-1:0] onehot_n;

    // Shadow copy, open only while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div      <= '0;
            cpol     <= 1'b0;
            cpha     <= 1'b0;
            sel_q    <= '0;
            decode_q <= 1'b0;
            d_setup  <= '0;
            d_hold   <= '0;
            d_desel  <= '0;
            d_gap    <= '0;
        end else if (!enable) begin
            div      <= in_div;
            cpol     <= in_cpol;
            cpha     <= in_cpha;
            sel_q    <= in_sel;
            decode_q <= in_decode;
            d_setup  <= in_setup;
            d_hold   <= in_hold;
            d_desel  <= in_desel;
            d_gap    <= in_gap;
        end
    end

    // One active-low line per index match; out-of-range index selects none.
    for (genvar i = 0; i < CS_W; i++) begin : g_onehot
        assign onehot_n[i] = (sel_q != CS_W'(i));
    end

    // Pick raw field or decoded index.
    always_comb begin
        pat = decode_q ? sel_q : onehot_n;
    end

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(enable) |-> $stable({div, cpol, cpha, sel_q, decode_q,
                                   d_setup, d_hold, d_desel, d_gap})); // R10
endmodule

// File: rtl/sct_sclk.sv
// Serial clock edge generator: while running, toggles the clock every
// div+1 reference cycles, counts edges and flags the final one, and
// strobes capture edges chosen by the phase bit. At rest it holds the
// polarity level. Assumes run and the configuration are stable while enabled.
module sct_sclk #(
    parameter int DIV_W = 4,
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             enable,
    input  logic [DIV_W-1:0] div,
    input  logic             cpol,
    input  logic             cpha,
    input  logic [LEN_W-1:0] len,
    output logic             sclk,
    output logic             cap_stb,
    output logic             last_edge
);
    localparam int CNT_W = LEN_W + 1;

    logic [DIV_W-1:0] hc;
    logic [CNT_W-1:0] cnt;
    logic             go;
    logic             tick;

    always_comb begin
        go        = run && enable;
        tick      = go && (hc == '0);
        last_edge = tick && (cnt == {len, 1'b1});
    end

    // Half-period counter, edge counter, clock level and capture strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hc      <= '0;
            cnt     <= '0;
            sclk    <= 1'b0;
            cap_stb <= 1'b0;
        end else if (!go) begin
            hc      <= div;
            cnt     <= '0;
            sclk    <= cpol;
            cap_stb <= 1'b0;
        end else if (tick) begin
            hc      <= div;
            cnt     <= cnt + 1'b1;
            sclk    <= ~sclk;
            cap_stb <= (cnt[0] == cpha);
        end else begin
            hc      <= hc - 1'b1;
            cap_stb <= 1'b0;
        end
    end

    AST_STB_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        cap_stb |-> (sclk != $past(sclk))); // R3
    AST_HALF_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (hc <= div)); // R1
    AST_SCLK_REST: assert property (@(posedge clk) disable iff (!rst_n)
        (!go && !$past(go) && $stable(cpol)) |-> (sclk == cpol)); // R2
endmodule

// File: rtl/sct_seq.sv
// Transaction sequencer: accepts a start while idle and enabled, then walks
// gap, setup, run, hold and deselect phases with one shared down-counter,
// and drives the registered select lines. Hold and deselect carry a fixed
// overhead of one serial period plus three and one reference cycles.
// Assumes last_edge comes from the edge generator while in the run phase.
module sct_seq #(
    parameter int DIV_W = 4,
    parameter int CS_W  = 4,
    parameter int DLY_W = 8,
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             start,
    input  logic [LEN_W-1:0] len,
    input  logic [DIV_W-1:0] div,
    input  logic [DLY_W-1:0] d_setup,
    input  logic [DLY_W-1:0] d_hold,
    input  logic [DLY_W-1:0] d_desel,
    input  logic [DLY_W-1:0] d_gap,
    input  logic [CS_W-1:0]  pat,
    input  logic             last_edge,
    output logic             run,
    output logic [LEN_W-1:0] len_q,
    output logic [CS_W-1:0]  cs_n,
    output logic             idle
);
    import sct_pkg::*;

    localparam int TMR_W = DLY_W + DIV_W + 2;

    sct_state_e       st, nx;
    logic [TMR_W-1:0] tmr, tmr_nx;
    logic [TMR_W-1:0] hold_ld, desel_ld;
    logic [CS_W-1:0]  last_pat;
    logic             has_prev;
    logic             accept;
    logic             tz;

    // Reload values including the fixed overhead.
    always_comb begin
        hold_ld  = TMR_W'(d_hold)  + (TMR_W'(div) << 1) + TMR_W'(4);
        desel_ld = TMR_W'(d_desel) + (TMR_W'(div) << 1) + TMR_W'(2);
        accept   = enable && start && (st == ST_IDLE);
        tz       = (tmr == '0);
    end

    // Next phase and next timer value.
    always_comb begin
        nx     = st;
        tmr_nx = tz ? tmr : tmr - 1'b1;
        case (st)
            ST_IDLE: if (accept) begin
                if (has_prev && (pat != last_pat) && (d_gap != '0)) begin
                    nx     = ST_GAP;
                    tmr_nx = TMR_W'(d_gap) - 1'b1;
                end else begin
                    nx     = ST_SETUP;
                    tmr_nx = TMR_W'(d_setup);
                end
            end
            ST_GAP: if (tz) begin
                nx     = ST_SETUP;
                tmr_nx = TMR_W'(d_setup);
            end
            ST_SETUP: if (tz) nx = ST_RUN;
            ST_RUN: if (last_edge) begin
                nx     = ST_HOLD;
                tmr_nx = hold_ld;
            end
            ST_HOLD: if (tz) begin
                nx     = ST_DESEL;
                tmr_nx = desel_ld;
            end
            ST_DESEL: if (tz) nx = ST_IDLE;
            default: nx = ST_IDLE;
        endcase
        if (!enable) begin
            nx     = ST_IDLE;
            tmr_nx = '0;
        end
    end

    // Phase, timer and select registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
            tmr <= '0;
            cs_n <= '1;
        end else begin
            st <= nx;
            tmr <= tmr_nx;
            cs_n <= (nx == ST_SETUP || nx == ST_RUN || nx == ST_HOLD) ? pat : '1;
        end
    end

    // Memory of the previous transaction's select pattern and length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            has_prev <= 1'b0;
            last_pat <= '1;
            len_q    <= '0;
        end else if (accept) begin
            has_prev <= 1'b1;
            last_pat <= pat;
            len_q    <= len;
        end
    end

    always_comb begin
        run  = (st == ST_RUN);
        idle = (st == ST_IDLE);
    end

    AST_IDLE_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (&cs_n)); // R8
    AST_ABORT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (idle && (&cs_n))); // R12
    AST_CS_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> $stable(cs_n)); // R4
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && enable && !$past(!enable)) |=> !idle || $past(st == ST_DESEL)); // R11
endmodule

// File: rtl/sclk_cs_timer.sv
// Top of the serial clock and select timer: configuration shadow,
// transaction sequencer and serial clock edge generator.
// Assumes configuration is changed only while enable is low.
module sclk_cs_timer #(
    parameter int DIV_W = 4,
    parameter int CS_W  = 4,
    parameter int DLY_W = 8,
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             cfg_cpol,
    input  logic             cfg_cpha,
    input  logic [CS_W-1:0]  cfg_sel,
    input  logic             cfg_decode,
    input  logic [DLY_W-1:0] cfg_setup_dly,
    input  logic [DLY_W-1:0] cfg_hold_dly,
    input  logic [DLY_W-1:0] cfg_desel_dly,
    input  logic [DLY_W-1:0] cfg_gap_dly,
    input  logic             xfer_start,
    input  logic [LEN_W-1:0] xfer_len,
    output logic             sclk,
    output logic [CS_W-1:0]  cs_n,
    output logic             cap_stb,
    output logic             idle
);
    logic [DIV_W-1:0] div;
    logic             cpol, cpha;
    logic [DLY_W-1:0] d_setup, d_hold, d_desel, d_gap;
    logic [CS_W-1:0]  pat;
    logic             run, last_edge;
    logic [LEN_W-1:0] len_q;

    sct_cfg #(.DIV_W(DIV_W), .CS_W(CS_W), .DLY_W(DLY_W)) i_cfg (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .in_div(cfg_div), .in_cpol(cfg_cpol), .in_cpha(cfg_cpha),
        .in_sel(cfg_sel), .in_decode(cfg_decode),
        .in_setup(cfg_setup_dly), .in_hold(cfg_hold_dly),
        .in_desel(cfg_desel_dly), .in_gap(cfg_gap_dly),
        .div(div), .cpol(cpol), .cpha(cpha),
        .d_setup(d_setup), .d_hold(d_hold), .d_desel(d_desel), .d_gap(d_gap),
        .pat(pat)
    );

    sct_seq #(.DIV_W(DIV_W), .CS_W(CS_W), .DLY_W(DLY_W), .LEN_W(LEN_W)) i_seq (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .start(xfer_start), .len(xfer_len), .div(div),
        .d_setup(d_setup), .d_hold(d_hold), .d_desel(d_desel), .d_gap(d_gap),
        .pat(pat), .last_edge(last_edge),
        .run(run), .len_q(len_q), .cs_n(cs_n), .idle(idle)
    );

    sct_sclk #(.DIV_W(DIV_W), .LEN_W(LEN_W)) i_sclk (
        .clk(clk), .rst_n(rst_n), .run(run), .enable(enable),
        .div(div), .cpol(cpol), .cpha(cpha), .len(len_q),
        .sclk(sclk), .cap_stb(cap_stb), .last_edge(last_edge)
    );
endmodule

// File: tb/test_sclk_cs_timer.sv
module test_sclk_cs_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [3:0] cfg_div = '0;
    logic       cfg_cpol = 1'b0, cfg_cpha = 1'b0;
    logic [3:0] cfg_sel = '0;
    logic       cfg_decode = 1'b0;
    logic [7:0] cfg_setup_dly = '0, cfg_hold_dly = '0, cfg_desel_dly = '0, cfg_gap_dly = '0;
    logic       xfer_start = 1'b0;
    logic [7:0] xfer_len = '0;
    logic       sclk, cap_stb, idle;
    logic [3:0] cs_n;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    // applied configuration as the bench believes the block holds it
    int a_div, a_cpol, a_cpha, a_sel, a_dec, a_ds, a_dh, a_dd, a_dg;
    int has_prev = 0;
    int last_pat = 15;

    // measurement results
    int m_cs_on, m_cs_off, m_cs_val, m_idle, m_fe, m_le, m_ne, m_ns;
    int m_bad_sp, m_bad_stb, m_bad_cs;

    sclk_cs_timer i_sclk_cs_timer (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .cfg_div(cfg_div), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_sel(cfg_sel), .cfg_decode(cfg_decode),
        .cfg_setup_dly(cfg_setup_dly), .cfg_hold_dly(cfg_hold_dly),
        .cfg_desel_dly(cfg_desel_dly), .cfg_gap_dly(cfg_gap_dly),
        .xfer_start(xfer_start), .xfer_len(xfer_len),
        .sclk(sclk), .cs_n(cs_n), .cap_stb(cap_stb), .idle(idle)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_pat(input int dec, input int sel);
        if (dec != 0) return sel;
        if (sel < 4) return 15 & ~(1 << sel);
        return 15;
    endfunction

    task automatic set_cfg(input int dv, input int pol, input int pha, input int sel,
                           input int dec, input int ds, input int dh, input int dd, input int dg);
        @(negedge clk);
        enable = 1'b0;
        cfg_div = 4'(dv); cfg_cpol = pol[0]; cfg_cpha = pha[0];
        cfg_sel = 4'(sel); cfg_decode = dec[0];
        cfg_setup_dly = 8'(ds); cfg_hold_dly = 8'(dh);
        cfg_desel_dly = 8'(dd); cfg_gap_dly = 8'(dg);
        a_div = dv; a_cpol = pol; a_cpha = pha; a_sel = sel; a_dec = dec;
        a_ds = ds; a_dh = dh; a_dd = dd; a_dg = dg;
        @(posedge clk);
        @(negedge clk);
        enable = 1'b1;
        @(posedge clk);
        @(negedge clk);
    endtask

    // Issue a start and record port events, indexed from the accepting edge.
    task automatic do_xfer(input int n);
        logic ps;
        int exp_lvl;
        int pat;
        pat = exp_pat(a_dec, a_sel);
        exp_lvl = (a_cpha != 0) ? a_cpol : 1 - a_cpol;
        m_cs_on = -1; m_cs_off = -1; m_cs_val = -1; m_idle = -1;
        m_fe = -1; m_le = -1; m_ne = 0; m_ns = 0;
        m_bad_sp = 0; m_bad_stb = 0; m_bad_cs = 0;
        @(negedge clk);
        xfer_start = 1'b1;
        xfer_len = 8'(n);
        ps = sclk;
        @(posedge clk);
        @(negedge clk);
        xfer_start = 1'b0;
        for (int k = 0; k < 6000; k++) begin
            if (sclk != ps) begin
                if (m_ne > 0 && (k - m_le) != a_div + 1) m_bad_sp++;
                if (m_ne == 0) m_fe = k;
                m_le = k;
                m_ne++;
            end
            if (cap_stb) begin
                m_ns++;
                if (sclk == ps || int'(sclk) != exp_lvl) m_bad_stb++;
            end
            if (m_cs_on < 0 && cs_n != 4'hF) begin
                m_cs_on = k;
                m_cs_val = int'(cs_n);
            end else if (m_cs_on >= 0 && m_cs_off < 0) begin
                if (cs_n == 4'hF) m_cs_off = k;
                else if (int'(cs_n) != pat) m_bad_cs++;
            end
            ps = sclk;
            if (idle) begin
                m_idle = k;
                break;
            end
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // Compare a recorded transaction against the timing requirements.
    task automatic verify(input string tag, input int n);
        int h, pat, g, fe, le, off, idl;
        h = a_div + 1;
        pat = exp_pat(a_dec, a_sel);
        g = (has_prev != 0 && pat != last_pat && a_dg != 0) ? a_dg : 0;
        has_prev = 1;
        last_pat = pat;
        fe = g + a_ds + 1 + h;
        le = fe + h * (2 * (n + 1) - 1);
        off = le + a_dh + 2 * h + 3;
        idl = off + a_dd + 2 * h + 1;
        $display("%s: checking transaction n=%0d", tag, n);
        check("R1 edge spacing errors", m_bad_sp, 0);
        check("R2 edge count", m_ne, 2 * (n + 1));
        check("R2 rest level after transaction", int'(sclk), a_cpol);
        check("R3 strobe count", m_ns, n + 1);
        check("R3 strobe placement errors", m_bad_stb, 0);
        check("R6 first edge cycle", m_fe, fe);
        check("R7 last edge cycle", m_le, le);
        check("R8 idle rise cycle", m_idle, idl);
        if (pat != 15) begin
            check("R9 select assert cycle", m_cs_on, g);
            check("R4/R5 select pattern", m_cs_val, pat);
            check("R4 select steady", m_bad_cs, 0);
            check("R7 deselect cycle", m_cs_off, off);
            check("R8 deselect length", m_idle - m_cs_off, a_dd + 2 * h + 1);
        end else begin
            check("R4 no select for out-of-range index", m_cs_on, -1);
        end
    endtask

    task automatic t_reset();
        check("R12 reset idle", int'(idle), 1);
        check("R12 reset selects", int'(cs_n), 15);
        check("R2 reset clock", int'(sclk), 0);
        check("R3 reset strobe", int'(cap_stb), 0);
    endtask

    task automatic t_mode0_onehot();
        set_cfg(1, 0, 0, 2, 0, 2, 1, 3, 0);
        do_xfer(3);
        verify("R1_R4_mode0", 3);
    endtask

    task automatic t_mode3_fast();
        set_cfg(0, 1, 1, 0, 0, 0, 0, 0, 0);
        check("R2 rest high before transaction", int'(sclk), 1);
        do_xfer(5);
        verify("R3_mode3", 5);
    endtask

    task automatic t_decoded_gap();
        set_cfg(3, 0, 1, 10, 1, 4, 2, 1, 5);
        do_xfer(1);
        verify("R5_R9_gap_new_device", 1);
        do_xfer(2);
        verify("R9_same_device", 2);
    endtask

    task automatic t_out_of_range();
        set_cfg(2, 0, 0, 6, 0, 1, 1, 1, 0);
        do_xfer(0);
        verify("R4_index6", 0);
    endtask

    task automatic t_frozen_cfg();
        set_cfg(1, 0, 0, 1, 0, 3, 2, 2, 0);
        @(negedge clk);
        cfg_div = 4'd7; cfg_cpol = 1'b1; cfg_sel = 4'd3; cfg_setup_dly = 8'd40;
        @(posedge clk);
        check("R10 rest level ignores live change", int'(sclk), 0);
        do_xfer(2);
        verify("R10_frozen", 2);
    endtask

    task automatic t_start_rules();
        int seen_cs;
        set_cfg(0, 0, 0, 0, 0, 1, 1, 1, 0);
        @(negedge clk);
        enable = 1'b0;
        xfer_start = 1'b1;
        seen_cs = 0;
        for (int k = 0; k < 4; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (cs_n != 4'hF || !idle) seen_cs++;
        end
        xfer_start = 1'b0;
        check("R11 start ignored while disabled", seen_cs, 0);
        enable = 1'b1;
        @(posedge clk);
        @(negedge clk);
        xfer_start = 1'b1;
        xfer_len = 8'd1;
        @(posedge clk);
        @(negedge clk);
        check("R11 idle falls on accept", int'(idle), 0);
        for (int k = 0; k < 3; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
        xfer_start = 1'b0;
        while (!idle) begin
            @(posedge clk);
            @(negedge clk);
        end
        seen_cs = 0;
        for (int k = 0; k < 8; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (cs_n != 4'hF || !idle) seen_cs++;
        end
        check("R11 start during busy not queued", seen_cs, 0);
        has_prev = 1;
        last_pat = exp_pat(a_dec, a_sel);
    endtask

    task automatic t_abort();
        set_cfg(0, 1, 0, 1, 0, 0, 0, 0, 0);
        @(negedge clk);
        xfer_start = 1'b1;
        xfer_len = 8'd30;
        @(posedge clk);
        @(negedge clk);
        xfer_start = 1'b0;
        for (int k = 0; k < 9; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
        check("R12 busy before abort", int'(idle), 0);
        enable = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R12 idle after abort", int'(idle), 1);
        check("R12 selects after abort", int'(cs_n), 15);
        check("R12 clock at rest after abort", int'(sclk), 1);
        check("R12 no strobe after abort", int'(cap_stb), 0);
        has_prev = 1;
        last_pat = exp_pat(a_dec, a_sel);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        t_reset();
        t_mode0_onehot();
        t_mode3_fast();
        t_decoded_gap();
        t_out_of_range();
        t_frozen_cfg();
        t_start_rules();
        t_abort();
        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule